// File: doc/BRIEF.md
# SPI Flash Page Program Engine

This block is the device-side command logic of a serial NOR flash for the page-program path. It watches a chip-select, serial clock and serial data input. All three are assumed already synchronous to the system clock. It recognises a write-enable opcode, a status-read opcode and the page-program opcode. For a program command it collects a 24-bit byte address and a stream of data bytes into a 256-byte staging buffer. The buffer position starts at the low address byte and wraps within the page.

A program command counts only when chip select is released on a byte boundary after at least one data byte. The block then runs a self-timed program cycle of a fixed number of system clocks. At the end of that cycle each byte that was sent is merged into a small register-modelled array. The merge is the AND of the old contents and the new data, as with erased cells that can only lose ones. The write-enable latch gates the command and block-protect levels on an input gate it further. The status byte reports busy, write-enable and protect state while a cycle runs. A combinational read port lets a neighbouring read path fetch array bytes.

Top module: `spi_pp_engine`

## Requirements
- R1: Bits are sampled on each rising serial-clock edge while chip select is low, MSB first. Opcode 0x02 is followed by three address bytes (high byte first) and then data bytes. Address bits [7:0] give the starting byte offset and bits [8+PG_W-1:8] give the page index, where PG_W = log2(NUM_PAGES). Higher address bits are ignored.
- R2: A program command seen while the write-enable latch is 0 is discarded with no effect on the array or status.
- R3: Each data byte goes to the current offset and the offset then increments modulo 256, staying in the same page. A byte sent to an offset already filled in the same command replaces the earlier one.
- R4: Array bytes at offsets not sent during the command, and all other pages, keep their contents.
- R5: The program cycle starts only if chip select rises when the bit count within the current byte is zero and at least one data byte was received. Any other release leaves the array, WIP and WEL unchanged.
- R6: After a valid release, WIP is 1 for exactly TPP_CYCLES system clocks and status reads are served meanwhile. When WIP falls, WEL is 0.
- R7: With protect level L (0..7) on prot_i, pages with index >= NUM_PAGES-L are protected. A program command aimed at a protected page is discarded and WEL stays set.
- R8: A programmed byte becomes the old array value ANDed with the sent value.
- R9: Opcode 0x06 sets WEL. Opcode 0x05 shifts out the status byte MSB first as {3'b000, prot_i[2:0], WEL, WIP}, with WIP at bit 0 and WEL at bit 1. The byte is refreshed after every further 8 clocks in the same frame. miso_o is 0 while chip select is high.
- R10: While WIP is 1, any opcode other than 0x05 is ignored, including 0x06 and 0x02.
- R11: After reset, WIP and WEL are 0 and every array byte reads 0xFF through arr_addr_i/arr_data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, sampled by clk_i |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out (status) |
| prot_i | input | 3 | Block-protect level |
| arr_addr_i | input | log2(NUM_PAGES*256) | Array read address {page, offset} |
| arr_data_o | output | 8 | Array read data |

## Verification
A wrong bit counter or missed termination check shows at the ports as WIP either rising after a misaligned release or failing to rise. This is visible in the first status frame after chip select goes high. A corrupt staging offset or mask shows up only once the cycle ends, as wrong or unexpectedly altered bytes on the array read port. The tests therefore probe both the target offsets and their neighbours. A stuck or mis-cleared write-enable latch shows in bit 1 of the very next status read, and in whether a following program command takes effect.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WENA  = 8'h06;
  localparam int unsigned PAGE_BYTES = 256;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_STAT,
    ST_SKIP
  } cmd_st_e;
endpackage

// File: rtl/spi_pp_shift.sv
module spi_pp_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       tx_load_i,
  input  logic [7:0] tx_byte_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       cs_rise_o,
  output logic       at_bound_o,
  output logic       miso_o
);
  logic       sck_q, cs_q, rise;
  logic [2:0] bit_cnt;
  logic [7:0] rx_q, tx_q;

  assign rise = sck_i & ~sck_q & ~cs_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= 1'b0;
      cs_q       <= 1'b1;
      bit_cnt    <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      sck_q      <= sck_i;
      cs_q       <= cs_ni;
      byte_vld_o <= rise && (bit_cnt == 3'd7);
      if (cs_ni)     bit_cnt <= '0;
      else if (rise) bit_cnt <= bit_cnt + 3'd1;
      if (rise) rx_q <= {rx_q[6:0], mosi_i};
      // load wins: a fresh status byte is presented before the next rising edge
      if (cs_ni)          tx_q <= '0;
      else if (tx_load_i) tx_q <= tx_byte_i;
      else if (rise)      tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  assign byte_o     = rx_q;
  assign cs_rise_o  = cs_ni & ~cs_q;
  assign at_bound_o = (bit_cnt == 3'd0);
  assign miso_o     = tx_q[7] & ~cs_ni;
endmodule

// File: rtl/spi_pp_cmd.sv
module spi_pp_cmd
  import spi_pp_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 4,
  localparam int unsigned PG_W  = $clog2(NUM_PAGES),
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             byte_vld_i,
  input  logic [7:0]                       byte_i,
  input  logic                             cs_rise_i,
  input  logic                             at_bound_i,
  input  logic                             wip_i,
  input  logic                             done_i,
  input  logic [2:0]                       prot_i,
  output logic                             tx_load_o,
  output logic [7:0]                       tx_byte_o,
  output logic                             start_o,
  output logic [PG_W-1:0]                  page_o,
  output logic [PAGE_BYTES-1:0][7:0]       buf_o,
  output logic [PAGE_BYTES-1:0]            mask_o,
  output logic                             wel_o
);
  cmd_st_e                    st;
  logic [1:0]                 acnt;
  logic [PG_W-1:0]            pg_q;
  logic [OFF_W-1:0]           off_q;
  logic                       got_q, wel_q, prot_hit;
  logic [PAGE_BYTES-1:0]      mask_q;
  logic [PAGE_BYTES-1:0][7:0] buf_q;
  logic [PG_W+3:0]            prot_sum;

  assign prot_sum = {4'd0, pg_q} + {{(PG_W+1){1'b0}}, prot_i};
  assign prot_hit = (prot_sum >= (PG_W+4)'(NUM_PAGES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= ST_OPC;
      acnt   <= '0;
      pg_q   <= '0;
      off_q  <= '0;
      got_q  <= 1'b0;
      mask_q <= '0;
      wel_q  <= 1'b0;
    end else begin
      if (done_i) wel_q <= 1'b0;
      else if (byte_vld_i && st == ST_OPC && !wip_i && byte_i == OP_WENA) wel_q <= 1'b1;

      if (cs_rise_i) begin
        st <= ST_OPC;
      end else if (byte_vld_i) begin
        unique case (st)
          ST_OPC: begin
            if (byte_i == OP_STAT) st <= ST_STAT;
            else if (!wip_i && wel_q && byte_i == OP_PROG) begin
              st   <= ST_ADDR;
              acnt <= '0;
            end else st <= ST_SKIP;
          end
          ST_ADDR: begin
            acnt <= acnt + 2'd1;
            if (acnt == 2'd1) pg_q <= byte_i[PG_W-1:0];
            if (acnt == 2'd2) begin
              st     <= prot_hit ? ST_SKIP : ST_DATA;
              off_q  <= byte_i[OFF_W-1:0];
              got_q  <= 1'b0;
              mask_q <= '0;
            end
          end
          ST_DATA: begin
            mask_q[off_q] <= 1'b1;
            off_q         <= off_q + 1'b1;  // wraps inside the page
            got_q         <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (byte_vld_i && st == ST_DATA) buf_q[off_q] <= byte_i;
  end

  assign start_o   = cs_rise_i && at_bound_i && got_q && (st == ST_DATA);
  assign tx_load_o = byte_vld_i && ((st == ST_OPC && byte_i == OP_STAT) || st == ST_STAT);
  assign tx_byte_o = {3'b000, prot_i, wel_q, wip_i};
  assign page_o    = pg_q;
  assign buf_o     = buf_q;
  assign mask_o    = mask_q;
  assign wel_o     = wel_q;
endmodule

// File: rtl/spi_pp_array.sv
module spi_pp_array
  import spi_pp_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 4,
  parameter int unsigned TPP_CYCLES = 64,
  localparam int unsigned PG_W  = $clog2(NUM_PAGES),
  localparam int unsigned OFF_W = $clog2(PAGE_BYTES),
  localparam int unsigned AW    = PG_W + OFF_W,
  localparam int unsigned CW    = $clog2(TPP_CYCLES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [PG_W-1:0]            page_i,
  input  logic [PAGE_BYTES-1:0][7:0] buf_i,
  input  logic [PAGE_BYTES-1:0]      mask_i,
  input  logic [AW-1:0]              rd_addr_i,
  output logic [7:0]                 rd_data_o,
  output logic                       wip_o,
  output logic                       done_o
);
  logic [CW-1:0]              cnt_q;
  logic                       wip_q;
  logic [PG_W-1:0]            pg_q;
  logic [PAGE_BYTES-1:0][7:0] col_rd;
  logic [PG_W-1:0]            rd_pg;
  logic [OFF_W-1:0]           rd_off;

  assign rd_pg  = rd_addr_i[AW-1:OFF_W];
  assign rd_off = rd_addr_i[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_q <= 1'b0;
      cnt_q <= '0;
      pg_q  <= '0;
    end else if (start_i && !wip_q) begin
      wip_q <= 1'b1;
      cnt_q <= CW'(TPP_CYCLES - 1);
      pg_q  <= page_i;
    end else if (wip_q) begin
      if (cnt_q == '0) wip_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = wip_q && (cnt_q == '0);
  assign wip_o  = wip_q;

  // one column of NUM_PAGES bytes per page offset
  for (genvar o = 0; o < PAGE_BYTES; o++) begin : g_col
    logic [7:0] col_q [NUM_PAGES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int p = 0; p < NUM_PAGES; p++) col_q[p] <= 8'hFF;
      end else if (done_o && mask_i[o]) begin
        col_q[pg_q] <= col_q[pg_q] & buf_i[o];
      end
    end
    assign col_rd[o] = col_q[rd_pg];
  end

  assign rd_data_o = col_rd[rd_off];
endmodule

// File: rtl/spi_pp_engine.sv
module spi_pp_engine
  import spi_pp_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 4,
  parameter int unsigned TPP_CYCLES = 64,
  localparam int unsigned PG_W = $clog2(NUM_PAGES),
  localparam int unsigned AW   = PG_W + $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sck_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic [2:0]    prot_i,
  input  logic [AW-1:0] arr_addr_i,
  output logic [7:0]    arr_data_o
);
  logic                       byte_vld, cs_rise, at_bound, tx_load;
  logic [7:0]                 rx_byte, tx_byte;
  logic                       pp_start, wip, wel, done;
  logic [PG_W-1:0]            page;
  logic [PAGE_BYTES-1:0][7:0] pbuf;
  logic [PAGE_BYTES-1:0]      pmask;

  spi_pp_shift i_shift (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .mosi_i,
    .tx_load_i  (tx_load),
    .tx_byte_i  (tx_byte),
    .byte_vld_o (byte_vld),
    .byte_o     (rx_byte),
    .cs_rise_o  (cs_rise),
    .at_bound_o (at_bound),
    .miso_o
  );

  spi_pp_cmd #(.NUM_PAGES(NUM_PAGES)) i_cmd (
    .clk_i, .rst_ni,
    .byte_vld_i (byte_vld),
    .byte_i     (rx_byte),
    .cs_rise_i  (cs_rise),
    .at_bound_i (at_bound),
    .wip_i      (wip),
    .done_i     (done),
    .prot_i,
    .tx_load_o  (tx_load),
    .tx_byte_o  (tx_byte),
    .start_o    (pp_start),
    .page_o     (page),
    .buf_o      (pbuf),
    .mask_o     (pmask),
    .wel_o      (wel)
  );

  spi_pp_array #(.NUM_PAGES(NUM_PAGES), .TPP_CYCLES(TPP_CYCLES)) i_array (
    .clk_i, .rst_ni,
    .start_i   (pp_start),
    .page_i    (page),
    .buf_i     (pbuf),
    .mask_i    (pmask),
    .rd_addr_i (arr_addr_i),
    .rd_data_o (arr_data_o),
    .wip_o     (wip),
    .done_o    (done)
  );
endmodule

// File: rtl/spi_pp_checker.sv
module spi_pp_checker #(
  parameter int unsigned NUM_PAGES  = 4,
  parameter int unsigned TPP_CYCLES = 64,
  localparam int unsigned PG_W = $clog2(NUM_PAGES),
  localparam int unsigned AW   = PG_W + 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_ni,
  input logic [2:0]      prot_i,
  input logic            start_i,
  input logic [PG_W-1:0] page_i,
  input logic            wip_i,
  input logic            wel_i,
  input logic            done_i,
  input logic [AW-1:0]   arr_addr_i,
  input logic [7:0]      arr_data_i
);
  logic [31:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_cnt <= '0;
    else if (wip_i) hi_cnt <= hi_cnt + 32'd1;
    else            hi_cnt <= '0;
  end

  assert_start_on_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cs_ni);
  assert_start_needs_wel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> wel_i);
  assert_no_start_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !wip_i);
  assert_start_unprotected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (int'(page_i) + int'(prot_i) < int'(NUM_PAGES)));
  assert_wip_rise_from_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(start_i));
  assert_wip_length_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> (hi_cnt == TPP_CYCLES));
  assert_wel_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> !wel_i);
  assert_array_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(arr_addr_i) && !$past(done_i)) |-> $stable(arr_data_i));
endmodule

bind spi_pp_engine spi_pp_checker #(.NUM_PAGES(NUM_PAGES), .TPP_CYCLES(TPP_CYCLES)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .prot_i     (prot_i),
  .start_i    (pp_start),
  .page_i     (page),
  .wip_i      (wip),
  .wel_i      (wel),
  .done_i     (done),
  .arr_addr_i (arr_addr_i),
  .arr_data_i (arr_data_o)
);

// File: tb/test_spi_pp_engine.sv
module test_spi_pp_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NPG        = 4;
  localparam int TPP        = 1000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic       miso;
  logic [2:0] prot = 3'd0;
  logic [9:0] arr_addr = '0;
  logic [7:0] arr_data;
  int         n_chk = 0, n_fail = 0;
  logic [7:0] pat [512];

  spi_pp_engine #(.NUM_PAGES(NPG), .TPP_CYCLES(TPP)) i_spi_pp_engine (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .miso_o(miso), .prot_i(prot), .arr_addr_i(arr_addr), .arr_data_o(arr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sbits(input logic [7:0] d, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = d[i];
      tick(HALF);
      r = {r[6:0], miso};
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic sbyte(input logic [7:0] d);
    logic [7:0] r;
    sbits(d, 8, r);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    tick(2);
  endtask

  task automatic cs_hi();
    tick(2);
    cs_n = 1'b1;
    tick(3);
  endtask

  task automatic wren();
    cs_lo(); sbyte(8'h06); cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    cs_lo(); sbyte(8'h05); sbits(8'h00, 8, s); cs_hi();
  endtask

  // opcode, address and n bytes of pat; chip select left low
  task automatic pp_head(input int addr, input int n);
    cs_lo();
    sbyte(8'h02);
    sbyte(8'(addr >> 16)); sbyte(8'(addr >> 8)); sbyte(8'(addr));
    for (int k = 0; k < n; k++) sbyte(pat[k]);
  endtask

  task automatic arr_rd(input int a, output logic [7:0] d);
    arr_addr = 10'(a);
    tick(1);
    d = arr_data;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 40; i++) begin
      rd_status(s);
      if (s[0] == 1'b0) break;
    end
    check("R6", "wip clears", 32'(s[0]), 32'd0);
  endtask

  task automatic t_reset();
    logic [7:0] s, d;
    rd_status(s);
    check("R11", "status after reset", 32'(s), 32'h00);
    arr_rd(0, d);     check("R11", "arr[0]", 32'(d), 32'hFF);
    arr_rd(1023, d);  check("R11", "arr[1023]", 32'(d), 32'hFF);
  endtask

  task automatic t_no_wel();
    logic [7:0] s, d;
    pat[0] = 8'h00;
    pp_head(24'h000010, 1); cs_hi();
    rd_status(s);
    check("R2", "status after ungated pp", 32'(s), 32'h00);
    arr_rd(16, d);
    check("R2", "array untouched", 32'(d), 32'hFF);
  endtask

  task automatic t_basic();
    logic [7:0] s, d;
    wren();
    rd_status(s);
    check("R9", "status after wren", 32'(s), 32'h02);
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'hF0;
    pp_head(24'h000110, 3); cs_hi();
    rd_status(s);
    check("R6", "busy status", 32'(s), 32'h03);
    arr_rd(16'h110, d);
    check("R6", "array holds during cycle", 32'(d), 32'hFF);
    wait_idle();
    rd_status(s);
    check("R6", "wel cleared after cycle", 32'(s), 32'h00);
    arr_rd(16'h110, d); check("R1", "byte0", 32'(d), 32'hA5);
    arr_rd(16'h111, d); check("R1", "byte1", 32'(d), 32'h3C);
    arr_rd(16'h112, d); check("R1", "byte2", 32'(d), 32'hF0);
    arr_rd(16'h10F, d); check("R4", "below range", 32'(d), 32'hFF);
    arr_rd(16'h113, d); check("R4", "above range", 32'(d), 32'hFF);
    arr_rd(16'h010, d); check("R4", "other page", 32'(d), 32'hFF);
  endtask

  task automatic t_and();
    logic [7:0] d;
    wren();
    pat[0] = 8'h0F;
    pp_head(24'h000110, 1); cs_hi();
    wait_idle();
    arr_rd(16'h110, d); check("R8", "old AND new", 32'(d), 32'h05);
    arr_rd(16'h111, d); check("R8", "unsent neighbour", 32'(d), 32'h3C);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    wren();
    pat[0] = 8'h11; pat[1] = 8'h22; pat[2] = 8'h33;
    pp_head(24'h0002FE, 3); cs_hi();
    wait_idle();
    arr_rd(16'h2FE, d); check("R3", "wrap off FE", 32'(d), 32'h11);
    arr_rd(16'h2FF, d); check("R3", "wrap off FF", 32'(d), 32'h22);
    arr_rd(16'h200, d); check("R3", "wrap to off 0", 32'(d), 32'h33);
    arr_rd(16'h300, d); check("R4", "next page untouched", 32'(d), 32'hFF);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    for (int k = 0; k < 258; k++) pat[k] = 8'(k * 3 + 1);
    wren();
    pp_head(24'hFC0000, 258); cs_hi();  // high address bits ignored: page 0
    wait_idle();
    arr_rd(0, d);   check("R3", "overwrite off 0", 32'(d), 32'h01);
    arr_rd(1, d);   check("R3", "overwrite off 1", 32'(d), 32'h04);
    arr_rd(2, d);   check("R3", "first pass off 2", 32'(d), 32'h07);
    arr_rd(255, d); check("R3", "first pass off FF", 32'(d), 32'hFE);
  endtask

  task automatic t_abort();
    logic [7:0] s, d, r;
    wren();
    pat[0] = 8'h00;
    pp_head(24'h000120, 1);
    sbits(8'h00, 3, r);
    cs_hi();
    rd_status(s);
    check("R5", "mid-byte release status", 32'(s), 32'h02);
    pp_head(24'h000121, 0); cs_hi();
    rd_status(s);
    check("R5", "no-data release status", 32'(s), 32'h02);
    arr_rd(16'h120, d); check("R5", "array after aborts", 32'(d), 32'hFF);
  endtask

  task automatic t_protect();
    logic [7:0] s, d;
    prot = 3'd1;
    pat[0] = 8'h00;
    pp_head(24'h000305, 1); cs_hi();
    rd_status(s);
    check("R7", "protected page rejected", 32'(s), 32'h06);
    arr_rd(16'h305, d); check("R7", "protected byte", 32'(d), 32'hFF);
    pat[0] = 8'h5A;
    pp_head(24'h000280, 1); cs_hi();
    wait_idle();
    arr_rd(16'h280, d); check("R7", "unprotected page programmed", 32'(d), 32'h5A);
    prot = 3'd5;
    rd_status(s);
    check("R9", "protect bits in status", 32'(s), 32'h14);
    prot = 3'd0;
  endtask

  task automatic t_busy();
    logic [7:0] s0, s1, d;
    wren();
    pat[0] = 8'h77;
    pp_head(24'h000130, 1); cs_hi();
    cs_lo(); sbyte(8'h05); sbits(8'h00, 8, s0); sbits(8'h00, 8, s1); cs_hi();
    check("R9", "status byte 1 busy", 32'(s0), 32'h03);
    check("R9", "status byte 2 repeat", 32'(s1), 32'h03);
    pat[0] = 8'h00;
    pp_head(24'h000180, 1); cs_hi();
    wren();
    wait_idle();
    rd_status(s0);
    check("R10", "wren during busy ignored", 32'(s0), 32'h00);
    arr_rd(16'h180, d); check("R10", "pp during busy ignored", 32'(d), 32'hFF);
    arr_rd(16'h130, d); check("R10", "first pp done", 32'(d), 32'h77);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_no_wel();
    t_basic();
    t_and();
    t_wrap();
    t_overflow();
    t_abort();
    t_protect();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule